// File: doc/BRIEF.md
# Dual-Chamber Pacing Controller

This block sequences pacing for the two chambers of the heart. It watches the upper chamber (atrium) and the lower chamber (ventricle) in turn. Each watch window starts by reloading that chamber's countdown timer. The window then ends in one of two ways. A natural sense event from the chamber ends it without pacing. If the timer runs out first, the block emits a one-cycle pace pulse for that chamber.

Whichever way an atrial window ends, the next ventricular window starts. Whichever way a ventricular window ends, the next atrial window starts. Both intervals are parameters counted in clock ticks. A full-rate build therefore uses large values, and a simulation build uses short ones. Sense front-ends and pulse amplitude belong to other blocks.

Top module: `dual_chamber_pacer`

## Requirements
- R1: While `rst_n` is low, both pace outputs are 0. With no sensing, the first atrial pace is high in cycle `A_WAIT_TICKS`+1, counting the first rising edge after release as the start of cycle 0.
- R2: With no atrial sense, `atrium_pace_o` is high for exactly one cycle. That cycle is `A_WAIT_TICKS`+3 cycles after the cycle holding the previous ventricular event (a ventricular pace cycle, or the cycle in which an accepted ventricular sense was presented).
- R3: With no ventricular sense, `ventricle_pace_o` is high for exactly one cycle. That cycle is `V_WAIT_TICKS`+3 cycles after the cycle holding the previous atrial event (pace or accepted sense).
- R4: An atrial sense presented k cycles after the previous ventricular event, with 2 ≤ k ≤ `A_WAIT_TICKS`+2, is accepted. It suppresses that atrial pace, and the ventricular interval is timed from the sense cycle.
- R5: A ventricular sense presented k cycles after the previous atrial event, with 2 ≤ k ≤ `V_WAIT_TICKS`+2, is accepted. It suppresses that ventricular pace, and the atrial interval is timed from the sense cycle.
- R6: A sense in the last cycle of its window (k = interval+2, the cycle in which the timer reports expiry) still wins, and no pace is issued.
- R7: A sense 1 cycle after the previous event (the timer reload cycle) is ignored. A sense from the chamber not currently being watched is also ignored. Neither changes the pace timing.
- R8: The two pace outputs are never high in the same cycle, and neither stays high for two consecutive cycles.
- R9: Once reloaded, a timer reports expiry exactly after its interval in cycles, and keeps reporting it until the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; enters the atrial reload step |
| atrium_sense_i | input | 1 | Natural atrial activity detected in this cycle |
| ventricle_sense_i | input | 1 | Natural ventricular activity detected in this cycle |
| atrium_pace_o | output | 1 | One-cycle atrial pace request |
| ventricle_pace_o | output | 1 | One-cycle ventricular pace request |

## Verification
A controller that drops into the wrong chamber's wait step shows at the pins within one interval. The pace then fires from the wrong output, or the pulse arrives at an offset other than interval+3 from the previous event. A timer reloaded at the wrong moment or counting wrongly shifts the next pace by the error, which shows within one pacing period. Because every pace and every accepted sense resets the timing reference, each pace cycle is predicted exactly from the last event. A misaccepted or missed sense therefore appears by the next expected pace.

// File: rtl/pacer_pkg.sv
package pacer_pkg;

    typedef enum logic [2:0] {
        ARM_A   = 3'd0,
        WATCH_A = 3'd1,
        FIRE_A  = 3'd2,
        ARM_V   = 3'd3,
        WATCH_V = 3'd4,
        FIRE_V  = 3'd5
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   a_pace;
        logic   v_pace;
    } ctl_s;

endpackage

// File: rtl/pace_countdown.sv
module pace_countdown #(
    parameter int TICKS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reload,
    output logic expired
);
    localparam int CW = $clog2(TICKS + 1);
    localparam logic [CW-1:0] LOAD = CW'(TICKS);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (reload)
            cnt_d = LOAD;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    assert_reload_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (cnt_q == LOAD));

    assert_expiry_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !reload) |=> expired);

endmodule

// File: rtl/pace_sequencer.sv
module pace_sequencer
    import pacer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic a_sense,
    input  logic v_sense,
    input  logic a_expired,
    input  logic v_expired,
    output logic a_reload,
    output logic v_reload,
    output logic a_pace,
    output logic v_pace
);
    ctl_s ctl_d, ctl_q;

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.a_pace = 1'b0;
        ctl_d.v_pace = 1'b0;
        unique case (ctl_q.phase)
            ARM_A:   ctl_d.phase = WATCH_A;
            WATCH_A: begin
                if (a_sense)
                    ctl_d.phase = ARM_V;
                else if (a_expired) begin
                    ctl_d.phase  = FIRE_A;
                    ctl_d.a_pace = 1'b1;
                end
            end
            FIRE_A:  ctl_d.phase = ARM_V;
            ARM_V:   ctl_d.phase = WATCH_V;
            WATCH_V: begin
                if (v_sense)
                    ctl_d.phase = ARM_A;
                else if (v_expired) begin
                    ctl_d.phase  = FIRE_V;
                    ctl_d.v_pace = 1'b1;
                end
            end
            FIRE_V:  ctl_d.phase = ARM_A;
            default: ctl_d.phase = ARM_A;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.phase  <= ARM_A;
            ctl_q.a_pace <= 1'b0;
            ctl_q.v_pace <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign a_reload = (ctl_q.phase == ARM_A);
    assign v_reload = (ctl_q.phase == ARM_V);
    assign a_pace   = ctl_q.a_pace;
    assign v_pace   = ctl_q.v_pace;

    assert_no_dual_pace_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_pace && v_pace));

    assert_a_pulse_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        a_pace |=> !a_pace);

    assert_v_pulse_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        v_pace |=> !v_pace);

    assert_a_pace_needs_expiry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(a_pace) |-> ($past(a_expired) && !$past(a_sense)));

    assert_v_pace_needs_expiry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(v_pace) |-> ($past(v_expired) && !$past(v_sense)));

    assert_v_reload_after_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(v_reload) |-> ($past(a_pace) || $past(a_sense)));

endmodule

// File: rtl/dual_chamber_pacer.sv
module dual_chamber_pacer #(
    parameter int A_WAIT_TICKS = 100_000_000,
    parameter int V_WAIT_TICKS = 20_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic atrium_sense_i,
    input  logic ventricle_sense_i,
    output logic atrium_pace_o,
    output logic ventricle_pace_o
);
    logic a_reload, v_reload, a_expired, v_expired;

    pace_countdown #(.TICKS(A_WAIT_TICKS)) a_timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .reload  (a_reload),
        .expired (a_expired)
    );

    pace_countdown #(.TICKS(V_WAIT_TICKS)) v_timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .reload  (v_reload),
        .expired (v_expired)
    );

    pace_sequencer seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_sense   (atrium_sense_i),
        .v_sense   (ventricle_sense_i),
        .a_expired (a_expired),
        .v_expired (v_expired),
        .a_reload  (a_reload),
        .v_reload  (v_reload),
        .a_pace    (atrium_pace_o),
        .v_pace    (ventricle_pace_o)
    );

endmodule

// File: tb/dual_chamber_pacer_tb_top.sv
module dual_chamber_pacer_tb_top;
    localparam int NA = 10;
    localparam int NV = 14;
    localparam int NVEC = 10;
    // fields: atrial sense offset, ventricular sense offset,
    //         stray ventricular sense in atrial phase, stray atrial sense in ventricular phase
    localparam int VEC [NVEC][4] = '{
        '{0, 0, 0, 0},
        '{0, 0, 0, 0},
        '{5, 0, 0, 0},
        '{0, 7, 0, 0},
        '{2, 2, 0, 0},
        '{NA+2, NV+2, 0, 0},
        '{0, 0, 4, 6},
        '{1, 1, 0, 0},
        '{3, 9, 2, 3},
        '{0, 0, 0, 0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_sense = 1'b0;
    logic v_sense = 1'b0;
    logic a_pace, v_pace;
    int checks = 0;
    int fails = 0;
    int cur = 0;
    int ev = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    dual_chamber_pacer #(.A_WAIT_TICKS(NA), .V_WAIT_TICKS(NV)) dut_i (
        .clk               (clk),
        .rst_n             (rst_n),
        .atrium_sense_i    (a_sense),
        .ventricle_sense_i (v_sense),
        .atrium_pace_o     (a_pace),
        .ventricle_pace_o  (v_pace)
    );

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s cycle=%0d actual=%0d expected=%0d", req, cur, act, exp);
        end
    endtask

    // one watch window for one chamber, timed from the previous event ev
    task automatic run_phase(bit is_a, int n, int off, int xoff);
        bit acc = (off >= 2) && (off <= n + 2);
        int tgt = acc ? ev + off : ev + n + 3;
        while (cur < tgt) begin
            @(negedge clk);
            cur++;
            if (is_a) begin
                check(a_pace == (!acc && cur == tgt), acc ? "R4/R6" : (off == 1 ? "R7" : "R2"),
                      a_pace, int'(!acc && cur == tgt));
                check(v_pace == 1'b0, "R8", v_pace, 0);
                a_sense = (off != 0) && (cur == ev + off);
                v_sense = (xoff != 0) && (cur == ev + xoff);
            end else begin
                check(v_pace == (!acc && cur == tgt), acc ? "R5/R6" : (off == 1 ? "R7" : "R3"),
                      v_pace, int'(!acc && cur == tgt));
                check(a_pace == 1'b0, "R8", a_pace, 0);
                v_sense = (off != 0) && (cur == ev + off);
                a_sense = (xoff != 0) && (cur == ev + xoff);
            end
        end
        ev = tgt;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        a_sense = 1'b0;
        v_sense = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check(a_pace == 1'b0 && v_pace == 1'b0, "R1", {a_pace, v_pace}, 0);
        end
        rst_n = 1'b1;
        cur = -1;
        ev = -2;
    endtask

    initial begin
        do_reset();
        // R1: first atrial pace at cycle NA+1 with no sensing
        run_phase(1'b1, NA, 0, 0);
        check(cur == NA + 1, "R1", cur, NA + 1);
        run_phase(1'b0, NV, 0, 0);
        for (int i = 0; i < NVEC; i++) begin
            run_phase(1'b1, NA, VEC[i][0], VEC[i][2]);
            run_phase(1'b0, NV, VEC[i][1], VEC[i][3]);
        end
        // reset in the middle of a ventricular window, then restart timing (R1)
        run_phase(1'b1, NA, 0, 0);
        repeat (4) @(negedge clk);
        do_reset();
        run_phase(1'b1, NA, 0, 0);
        check(cur == NA + 1, "R1", cur, NA + 1);
        run_phase(1'b0, NV, 6, 0);
        run_phase(1'b1, NA, 0, 0);
        @(negedge clk);
        a_sense = 1'b0;
        v_sense = 1'b0;
        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

endmodule